// File: doc/BRIEF.md
# HDLC Receive Address Filter

This block sits directly behind an HDLC deframer. That stage has already done flag detection, bit destuffing and CRC handling. The filter receives the frame contents as a byte stream. Each byte is qualified by a valid strobe, and two markers flag the first and last byte of a frame.

The first two bytes of a frame form a 16-bit address. The filter holds on to these two bytes and compares the address with four programmable address registers in parallel. One shared mask register selects which bit positions take part in the comparison. If any register matches, the whole frame is forwarded with its original start and end markers and with no added gaps. If none matches, the frame is discarded. A broadcast address can be accepted by loading one of the registers with all ones.

A one-cycle decision strobe reports the outcome once per frame. Frames too short to carry an address are always dropped.

Top module: `hdlc_addr_filter`

## Requirements
- R1: While waiting for a frame, bytes presented with `in_valid` high but `in_sof` low are ignored: they produce no output byte and no decision strobe.
- R2: For each frame of two or more bytes, exactly one decision strobe (`dec_valid` high for one cycle) appears in the cycle after the second byte is accepted. `dec_hit` gives the outcome.
- R3: The received address is the first byte in bits 7:0 and the second byte in bits 15:8. It is compared with each address register only where `addr_mask` holds a 1. Bit positions where the mask is 0 never affect the outcome.
- R4: A frame is accepted when at least one of the four registers matches under the mask. Register k occupies bits 16k+15:16k of `addr_tbl`.
- R5: With one register set to 0xFFFF, a frame whose address is 0xFFFF is accepted under any mask.
- R6: An accepted frame is emitted byte for byte in its original order. The first byte appears in the decision cycle with `out_sof` high. The last byte carries `out_eof`.
- R7: A rejected frame produces no output byte.
- R8: A one-byte frame (`in_sof` and `in_eof` on the same byte) is dropped, and gives a decision strobe with `dec_hit` low in the next cycle.
- R9: Bytes of an accepted frame presented on consecutive cycles leave on consecutive cycles. The last byte leaves one cycle after it is accepted.
- R10: After the end-of-frame byte the filter waits for a new start of frame. A new frame may begin in the very next cycle.
- R11: A start-of-frame arriving before the current frame's end abandons that frame. Its most recent byte, not yet emitted, is discarded, and the new frame is filtered normally.
- R12: During and just after reset, `out_valid` and `dec_valid` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Input byte valid |
| in_data | input | DATA_W | Input byte |
| in_sof | input | 1 | Input byte is the first of a frame |
| in_eof | input | 1 | Input byte is the last of a frame |
| addr_tbl | input | NUM_ADDR*2*DATA_W | Address registers, register k in slice k |
| addr_mask | input | 2*DATA_W | Compare enable per address bit |
| out_valid | output | 1 | Output byte valid |
| out_data | output | DATA_W | Output byte |
| out_sof | output | 1 | Output byte is the first of a frame |
| out_eof | output | 1 | Output byte is the last of a frame |
| dec_valid | output | 1 | Address decision strobe |
| dec_hit | output | 1 | Decision outcome, 1 = accepted |

## Verification
The bench builds the filter with its default parameters: 8-bit bytes and four address registers. At this size the random address generator can place a received address exactly on a register, offset from it only in masked-off bits, or off every register. Partial-mask matches, hits on a single register and broadcast therefore all occur often alongside misses. Frame lengths run from one to eight bytes with zero to two idle cycles between bytes. This brings in two-byte frames whose final byte is also an address byte, back-to-back frames, and frames abandoned by an early start-of-frame.

// File: rtl/hdlc_af_pkg.sv
package hdlc_af_pkg;

  // Frame tracking states of the filter controller
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,   // waiting for a start of frame
    ST_ADDR = 2'd1,   // first address byte held, second expected
    ST_PASS = 2'd2,   // frame accepted, bytes forwarded
    ST_DROP = 2'd3    // frame rejected, bytes discarded
  } af_state_e;

endpackage

// File: rtl/hdlc_af_cmp.sv
module hdlc_af_cmp #(
  parameter int ADDR_W = 16
) (
  input  logic [ADDR_W-1:0] rx_addr,
  input  logic [ADDR_W-1:0] ref_addr,
  input  logic [ADDR_W-1:0] cmp_mask,
  output logic              hit
);

  logic [ADDR_W-1:0] diff;

  always_comb begin
    diff = (rx_addr ^ ref_addr) & cmp_mask;
    hit  = ~|diff;
  end

endmodule

// File: rtl/hdlc_af_match.sv
module hdlc_af_match #(
  parameter int ADDR_W   = 16,
  parameter int NUM_ADDR = 4
) (
  input  logic [ADDR_W-1:0]          rx_addr,
  input  logic [NUM_ADDR*ADDR_W-1:0] addr_tbl,
  input  logic [ADDR_W-1:0]          addr_mask,
  output logic [NUM_ADDR-1:0]        hit_vec,
  output logic                       any_hit
);

  for (genvar g = 0; g < NUM_ADDR; g++) begin : g_cmp
    hdlc_af_cmp #(
      .ADDR_W(ADDR_W)
    ) u_cmp (
      .rx_addr (rx_addr),
      .ref_addr(addr_tbl[g*ADDR_W +: ADDR_W]),
      .cmp_mask(addr_mask),
      .hit     (hit_vec[g])
    );
  end

  always_comb begin
    any_hit = |hit_vec;
  end

endmodule

// File: rtl/hdlc_af_ctrl.sv
module hdlc_af_ctrl
  import hdlc_af_pkg::*;
#(
  parameter int DATA_W   = 8,
  parameter int NUM_ADDR = 4
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           in_valid,
  input  logic [DATA_W-1:0]              in_data,
  input  logic                           in_sof,
  input  logic                           in_eof,
  input  logic [NUM_ADDR*2*DATA_W-1:0]   addr_tbl,
  input  logic [2*DATA_W-1:0]            addr_mask,
  output logic [DATA_W-1:0]              hold_data,
  output logic                           first_go,
  output logic                           pass_go,
  output logic                           kill,
  output logic                           dec_valid,
  output logic                           dec_hit
);

  localparam int ADDR_W = 2 * DATA_W;

  af_state_e         st_q, st_n;
  logic [DATA_W-1:0] hold_q;
  logic              hold_en;
  logic              dec_v_q, dec_v_n;
  logic              dec_h_q, dec_h_n;
  logic [ADDR_W-1:0] rx_addr;
  logic [NUM_ADDR-1:0] hit_vec;
  logic              match_hit;
  logic              bcast_armed;

  // second byte forms the upper half of the address
  always_comb begin
    rx_addr = {in_data, hold_q};
  end

  hdlc_af_match #(
    .ADDR_W  (ADDR_W),
    .NUM_ADDR(NUM_ADDR)
  ) u_match (
    .rx_addr  (rx_addr),
    .addr_tbl (addr_tbl),
    .addr_mask(addr_mask),
    .hit_vec  (hit_vec),
    .any_hit  (match_hit)
  );

  // next-state process
  always_comb begin
    st_n     = st_q;
    hold_en  = 1'b0;
    dec_v_n  = 1'b0;
    dec_h_n  = 1'b0;
    first_go = 1'b0;
    pass_go  = 1'b0;
    kill     = 1'b0;
    if (in_valid && in_sof) begin
      kill    = 1'b1;
      hold_en = 1'b1;
      if (in_eof) begin
        st_n    = ST_IDLE;
        dec_v_n = 1'b1;
      end else begin
        st_n = ST_ADDR;
      end
    end else if (in_valid) begin
      unique case (st_q)
        ST_ADDR: begin
          dec_v_n  = 1'b1;
          dec_h_n  = match_hit;
          first_go = match_hit;
          if (in_eof)         st_n = ST_IDLE;
          else if (match_hit) st_n = ST_PASS;
          else                st_n = ST_DROP;
        end
        ST_PASS: begin
          pass_go = 1'b1;
          if (in_eof) st_n = ST_IDLE;
        end
        ST_DROP: begin
          if (in_eof) st_n = ST_IDLE;
        end
        default: begin
          st_n = ST_IDLE;
        end
      endcase
    end
  end

  // register process
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= ST_IDLE;
      dec_v_q <= 1'b0;
      dec_h_q <= 1'b0;
    end else begin
      st_q    <= st_n;
      dec_v_q <= dec_v_n;
      dec_h_q <= dec_h_n;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_q <= '0;
    end else if (hold_en) begin
      hold_q <= in_data;
    end
  end

  always_comb begin
    hold_data = hold_q;
    dec_valid = dec_v_q;
    dec_hit   = dec_h_q;
  end

  always_comb begin
    bcast_armed = 1'b0;
    for (int i = 0; i < NUM_ADDR; i++) begin
      bcast_armed = bcast_armed | (&addr_tbl[i*ADDR_W +: ADDR_W]);
    end
  end

  // R1: stray bytes while idle never lead to a decision
  p_idle_ignore_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_IDLE && in_valid && !in_sof) |=> !dec_valid);

  // R3: an all-zero mask accepts any address
  p_mask_open_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_ADDR && in_valid && !in_sof && addr_mask == '0) |-> match_hit);

  // R5: all-ones address always accepted when a register holds all ones
  p_bcast_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_ADDR && in_valid && !in_sof && rx_addr == '1 && bcast_armed)
      |-> match_hit);

  // R8: one-byte frame yields a miss decision next cycle
  p_short_drop_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_sof && in_eof) |=> (dec_valid && !dec_hit));

endmodule

// File: rtl/hdlc_af_emit.sv
module hdlc_af_emit #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DATA_W-1:0] in_data,
  input  logic              in_eof,
  input  logic [DATA_W-1:0] hold_data,
  input  logic              first_go,
  input  logic              pass_go,
  input  logic              kill,
  output logic              out_valid,
  output logic [DATA_W-1:0] out_data,
  output logic              out_sof,
  output logic              out_eof
);

  logic              pend_v_q, pend_v_n;
  logic [DATA_W-1:0] pend_d_q;
  logic              pend_e_q;
  logic              pend_ld;
  logic              flush;
  logic              ov_q, ov_n;
  logic [DATA_W-1:0] od_q, od_n;
  logic              os_q, os_n;
  logic              oe_q, oe_n;

  // next-state process
  always_comb begin
    flush    = pend_v_q & pend_e_q;
    pend_ld  = first_go | pass_go;
    ov_n     = 1'b0;
    od_n     = od_q;
    os_n     = 1'b0;
    oe_n     = 1'b0;
    if (flush) begin
      ov_n = 1'b1;
      od_n = pend_d_q;
      oe_n = 1'b1;
    end else if (first_go) begin
      ov_n = 1'b1;
      od_n = hold_data;
      os_n = 1'b1;
    end else if (pass_go) begin
      ov_n = 1'b1;
      od_n = pend_d_q;
    end
    pend_v_n = pend_v_q;
    if (pend_ld)            pend_v_n = 1'b1;
    else if (flush || kill) pend_v_n = 1'b0;
  end

  // register processes
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_v_q <= 1'b0;
      ov_q     <= 1'b0;
      os_q     <= 1'b0;
      oe_q     <= 1'b0;
    end else begin
      pend_v_q <= pend_v_n;
      ov_q     <= ov_n;
      os_q     <= os_n;
      oe_q     <= oe_n;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_d_q <= '0;
      pend_e_q <= 1'b0;
    end else if (pend_ld) begin
      pend_d_q <= in_data;
      pend_e_q <= in_eof;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      od_q <= '0;
    end else if (ov_n) begin
      od_q <= od_n;
    end
  end

  always_comb begin
    out_valid = ov_q;
    out_data  = od_q;
    out_sof   = os_q;
    out_eof   = oe_q;
  end

  // R9: forwarding a byte always finds a buffered predecessor
  p_pass_pend_r9: assert property (@(posedge clk) disable iff (!rst_n)
    pass_go |-> pend_v_q);

  // R9: a buffered last byte leaves in the next cycle
  p_eof_flush_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_v_q && pend_e_q) |=> (out_valid && out_eof));

  // R10: flushing the old frame never collides with a new frame's output
  p_no_collide_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_v_q && pend_e_q) |-> !(first_go || pass_go));

endmodule

// File: rtl/hdlc_addr_filter.sv
module hdlc_addr_filter #(
  parameter int DATA_W   = 8,
  parameter int NUM_ADDR = 4
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         in_valid,
  input  logic [DATA_W-1:0]            in_data,
  input  logic                         in_sof,
  input  logic                         in_eof,
  input  logic [NUM_ADDR*2*DATA_W-1:0] addr_tbl,
  input  logic [2*DATA_W-1:0]          addr_mask,
  output logic                         out_valid,
  output logic [DATA_W-1:0]            out_data,
  output logic                         out_sof,
  output logic                         out_eof,
  output logic                         dec_valid,
  output logic                         dec_hit
);

  logic              rst_meta_q;
  logic              rst_sync_q;
  logic [DATA_W-1:0] hold_data;
  logic              first_go;
  logic              pass_go;
  logic              kill;

  // asynchronous assertion, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_q <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_q <= rst_meta_q;
    end
  end

  hdlc_af_ctrl #(
    .DATA_W  (DATA_W),
    .NUM_ADDR(NUM_ADDR)
  ) u_ctrl (
    .clk      (clk),
    .rst_n    (rst_sync_q),
    .in_valid (in_valid),
    .in_data  (in_data),
    .in_sof   (in_sof),
    .in_eof   (in_eof),
    .addr_tbl (addr_tbl),
    .addr_mask(addr_mask),
    .hold_data(hold_data),
    .first_go (first_go),
    .pass_go  (pass_go),
    .kill     (kill),
    .dec_valid(dec_valid),
    .dec_hit  (dec_hit)
  );

  hdlc_af_emit #(
    .DATA_W(DATA_W)
  ) u_emit (
    .clk      (clk),
    .rst_n    (rst_sync_q),
    .in_data  (in_data),
    .in_eof   (in_eof),
    .hold_data(hold_data),
    .first_go (first_go),
    .pass_go  (pass_go),
    .kill     (kill),
    .out_valid(out_valid),
    .out_data (out_data),
    .out_sof  (out_sof),
    .out_eof  (out_eof)
  );

  // R6, R7: a frame start leaves only together with a positive decision
  p_sof_with_hit_r6: assert property (@(posedge clk) disable iff (!rst_sync_q)
    (out_valid && out_sof) |-> (dec_valid && dec_hit));

  // R7: a negative decision never coincides with a frame start
  p_miss_silent_r7: assert property (@(posedge clk) disable iff (!rst_sync_q)
    (dec_valid && !dec_hit) |-> !(out_valid && out_sof));

endmodule

// File: tb/hdlc_addr_filter_tb.sv
`timescale 1ns/100ps
module hdlc_addr_filter_tb;

  localparam int DATA_W   = 8;
  localparam int NUM_ADDR = 4;

  logic                         clk = 1'b0;
  logic                         rst_n;
  logic                         in_valid;
  logic [DATA_W-1:0]            in_data;
  logic                         in_sof;
  logic                         in_eof;
  logic [NUM_ADDR*2*DATA_W-1:0] addr_tbl;
  logic [2*DATA_W-1:0]          addr_mask;
  logic                         out_valid;
  logic [DATA_W-1:0]            out_data;
  logic                         out_sof;
  logic                         out_eof;
  logic                         dec_valid;
  logic                         dec_hit;

  always #2 clk = ~clk;

  hdlc_addr_filter #(
    .DATA_W  (DATA_W),
    .NUM_ADDR(NUM_ADDR)
  ) u_dut (
    .clk      (clk),
    .rst_n    (rst_n),
    .in_valid (in_valid),
    .in_data  (in_data),
    .in_sof   (in_sof),
    .in_eof   (in_eof),
    .addr_tbl (addr_tbl),
    .addr_mask(addr_mask),
    .out_valid(out_valid),
    .out_data (out_data),
    .out_sof  (out_sof),
    .out_eof  (out_eof),
    .dec_valid(dec_valid),
    .dec_hit  (dec_hit)
  );

  logic [15:0] regs [NUM_ADDR];
  always_comb begin
    for (int i = 0; i < NUM_ADDR; i++) addr_tbl[i*16 +: 16] = regs[i];
  end

  int          total = 0;
  int          bad   = 0;
  int          cyc   = 0;
  int          out_cnt = 0;
  int          dec_cnt = 0;
  bit          mon_on  = 1'b0;
  logic [9:0]  exp_q[$];
  bit          exp_dec[$];
  string       exp_tag[$];
  int          beat_cyc[$];
  logic [7:0]  fr[$];
  string       cur_tag = "R6";

  // ---------------- monitor, samples away from the active edge
  always @(negedge clk) begin
    if (mon_on) begin
      cyc++;
      if (out_valid) begin
        out_cnt++;
        beat_cyc.push_back(cyc);
        total++;
        if (exp_q.size() == 0) begin
          bad++;
          $display("FAIL R7 unexpected output byte: actual=%h sof=%0b eof=%0b expected=none",
                   out_data, out_sof, out_eof);
        end else begin
          logic [9:0] e;
          e = exp_q.pop_front();
          if ({out_sof, out_eof, out_data} !== e) begin
            bad++;
            $display("FAIL R6 output beat: actual=%h expected=%h",
                     {out_sof, out_eof, out_data}, e);
          end
        end
      end
      if (dec_valid) begin
        dec_cnt++;
        total++;
        if (exp_dec.size() == 0) begin
          bad++;
          $display("FAIL R2 unexpected decision: actual hit=%0b expected=none", dec_hit);
        end else begin
          bit    h;
          string t;
          h = exp_dec.pop_front();
          t = exp_tag.pop_front();
          if (dec_hit !== h) begin
            bad++;
            $display("FAIL %s decision: actual=%0b expected=%0b", t, dec_hit, h);
          end
        end
      end
    end
  end

  // ---------------- reference functions
  function automatic bit model_hit(logic [15:0] a);
    for (int i = 0; i < NUM_ADDR; i++)
      if (((a ^ regs[i]) & addr_mask) == 16'h0) return 1'b1;
    return 1'b0;
  endfunction

  task automatic expect_frame(input bit with_eof);
    int n;
    n = fr.size();
    if (n >= 2) begin
      bit h;
      h = model_hit({fr[1], fr[0]});
      exp_dec.push_back(h);
      exp_tag.push_back(cur_tag);
      if (h) begin
        int last;
        last = with_eof ? n - 1 : n - 2;
        for (int k = 0; k <= last; k++)
          exp_q.push_back({(k == 0), (with_eof && k == n - 1), fr[k]});
      end
    end else if (n == 1 && with_eof) begin
      exp_dec.push_back(1'b0);
      exp_tag.push_back("R8");
    end
  endtask

  // drive one frame; entry and exit just after a rising edge
  task automatic send_frame(input bit with_eof, input int gap_max);
    expect_frame(with_eof);
    for (int i = 0; i < fr.size(); i++) begin
      in_valid = 1'b1;
      in_data  = fr[i];
      in_sof   = (i == 0);
      in_eof   = with_eof && (i == fr.size() - 1);
      @(posedge clk); #1;
      in_valid = 1'b0;
      in_sof   = 1'b0;
      in_eof   = 1'b0;
      if (gap_max > 0) begin
        int g;
        g = $urandom_range(gap_max, 0);
        repeat (g) begin @(posedge clk); #1; end
      end
    end
  endtask

  task automatic idle(input int n);
    repeat (n) begin @(posedge clk); #1; end
  endtask

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic set_regs(input logic [15:0] a0, input logic [15:0] a1,
                          input logic [15:0] a2, input logic [15:0] a3,
                          input logic [15:0] m);
    regs[0] = a0; regs[1] = a1; regs[2] = a2; regs[3] = a3;
    addr_mask = m;
  endtask

  task automatic summary;
    $display("  test done: total=%0d bad=%0d", total, bad);
  endtask

  // ---------------- watchdog
  initial begin
    repeat (150000) @(posedge clk);
    bad++;
    $display("FAIL watchdog: actual=expired expected=finished");
    summary();
    $finish;
  end

  // ---------------- stimulus
  initial begin
    void'($urandom(32'd4242));
    rst_n    = 1'b0;
    in_valid = 1'b0;
    in_data  = '0;
    in_sof   = 1'b0;
    in_eof   = 1'b0;
    set_regs(16'h0, 16'h0, 16'h0, 16'h0, 16'hFFFF);
    repeat (3) @(posedge clk);
    #1;
    check(out_valid === 1'b0 && dec_valid === 1'b0, "R12 outputs in reset",
          int'(out_valid) + int'(dec_valid), 0);
    rst_n = 1'b0;
    @(posedge clk); #1;
    rst_n = 1'b1;
    idle(1);
    check(out_valid === 1'b0 && dec_valid === 1'b0, "R12 outputs after release",
          int'(out_valid) + int'(dec_valid), 0);
    idle(4);
    mon_on = 1'b1;

    // R6 / R9: contiguous matching frame, address 0x1234
    cur_tag = "R6";
    set_regs(16'h1234, 16'hAAAA, 16'hBBBB, 16'hCCCC, 16'hFFFF);
    begin
      int s;
      s = beat_cyc.size();
      fr = '{8'h34, 8'h12, 8'h01, 8'h02, 8'h03, 8'h04};
      send_frame(1'b1, 0);
      idle(4);
      check(beat_cyc.size() == s + 6, "R6 accepted frame byte count", beat_cyc.size() - s, 6);
      if (beat_cyc.size() == s + 6)
        check(beat_cyc[s+5] - beat_cyc[s] == 5, "R9 no gaps in output",
              beat_cyc[s+5] - beat_cyc[s], 5);
    end

    // R1: stray bytes in idle
    begin
      int o, d;
      o = out_cnt; d = dec_cnt;
      for (int i = 0; i < 3; i++) begin
        in_valid = 1'b1; in_data = 8'h34 + 8'(i); in_sof = 1'b0; in_eof = (i == 2);
        @(posedge clk); #1;
      end
      in_valid = 1'b0; in_eof = 1'b0;
      idle(4);
      check(out_cnt == o && dec_cnt == d, "R1 stray bytes ignored",
            (out_cnt - o) + (dec_cnt - d), 0);
    end

    // R3: masked-off low nibble ignored, unmasked bit counts
    cur_tag = "R3";
    set_regs(16'h1234, 16'hAAAA, 16'hBBBB, 16'hCCCC, 16'hFFF0);
    fr = '{8'h3F, 8'h12, 8'h55}; send_frame(1'b1, 1);
    fr = '{8'h34, 8'h13, 8'h55}; send_frame(1'b1, 1);
    idle(3);

    // R4: only register 3 matches
    cur_tag = "R4";
    set_regs(16'h0001, 16'h0002, 16'h0003, 16'h7E81, 16'hFFFF);
    fr = '{8'h81, 8'h7E, 8'h10, 8'h20}; send_frame(1'b1, 0);
    idle(3);

    // R5: broadcast with and without an all-ones register
    cur_tag = "R5";
    set_regs(16'h0001, 16'h0002, 16'hFFFF, 16'h0004, 16'hFFFF);
    fr = '{8'hFF, 8'hFF, 8'h99}; send_frame(1'b1, 0);
    set_regs(16'h0001, 16'h0002, 16'hFFFE, 16'h0004, 16'hFFFF);
    fr = '{8'hFF, 8'hFF, 8'h99}; send_frame(1'b1, 0);
    idle(3);

    // R7: rejected frame, no output
    begin
      int o;
      cur_tag = "R7";
      o = out_cnt;
      fr = '{8'h00, 8'h00, 8'h11, 8'h22}; send_frame(1'b1, 0);
      idle(4);
      check(out_cnt == o, "R7 rejected frame silent", out_cnt - o, 0);
    end

    // R8: one-byte frame
    begin
      int o;
      o = out_cnt;
      fr = '{8'h01}; send_frame(1'b1, 0);
      idle(3);
      check(out_cnt == o, "R8 short frame silent", out_cnt - o, 0);
    end

    // R10: back-to-back accepted frames, two-byte frame included
    cur_tag = "R10";
    set_regs(16'h0201, 16'h0000, 16'h0000, 16'h0000, 16'hFFFF);
    begin
      int o;
      o = out_cnt;
      fr = '{8'h01, 8'h02}; send_frame(1'b1, 0);
      fr = '{8'h01, 8'h02, 8'hA0}; send_frame(1'b1, 0);
      fr = '{8'h01, 8'h02, 8'hB0, 8'hB1}; send_frame(1'b1, 0);
      idle(4);
      check(out_cnt == o + 9, "R10 back-to-back frames emitted", out_cnt - o, 9);
    end

    // R11: frame abandoned by a new start of frame
    cur_tag = "R11";
    begin
      int o;
      o = out_cnt;
      fr = '{8'h01, 8'h02, 8'hC0, 8'hC1}; send_frame(1'b0, 0);
      fr = '{8'h01, 8'h02, 8'hD0}; send_frame(1'b1, 0);
      idle(4);
      check(out_cnt == o + 6, "R11 abandoned frame truncated", out_cnt - o, 6);
    end

    // random frames
    cur_tag = "R4";
    for (int f = 0; f < 400; f++) begin
      int n, kind;
      logic [15:0] a, m;
      for (int i = 0; i < NUM_ADDR; i++) regs[i] = 16'($urandom);
      m = ($urandom_range(1, 0) == 1) ? 16'hFFFF : 16'($urandom);
      addr_mask = m;
      kind = $urandom_range(3, 0);
      if (kind <= 1) a = regs[$urandom_range(NUM_ADDR-1, 0)] ^ (16'($urandom) & ~m);
      else if (kind == 2) a = 16'($urandom);
      else begin regs[$urandom_range(NUM_ADDR-1, 0)] = 16'hFFFF; a = 16'hFFFF; end
      n = $urandom_range(8, 1);
      fr.delete();
      fr.push_back(a[7:0]);
      if (n > 1) fr.push_back(a[15:8]);
      for (int k = 2; k < n; k++) fr.push_back(8'($urandom));
      send_frame($urandom_range(9, 0) != 0, 2);
    end
    idle(10);

    check(exp_q.size() == 0, "R6 all expected bytes seen", exp_q.size(), 0);
    check(exp_dec.size() == 0, "R2 all expected decisions seen", exp_dec.size(), 0);
    summary();
    $finish;
  end

endmodule